// File: doc/BRIEF.md
# Receive Byte FIFO with Host Status Registers

This block buffers received data bytes for one receive channel until a host microcontroller collects them. A producer presents one byte per cycle on a valid strobe. The host reaches three registers through a plain address, read-strobe and write-strobe interface.

The first register is a data window. Each read of it returns the oldest stored byte and removes it, so reads can be issued back to back to stream the FIFO out. The second is a write-only threshold. The third is a read-only status word. The status word reports the fill level, a nearly-full trigger, and sticky overflow and underflow flags. The trigger, gated by an enable pin, drives a level interrupt request. One instance serves one channel, and a chip instantiates one per channel.

Top module: `rx_byte_fifo`

## Requirements
- R1: After reset the FIFO is empty, every status bit is 0, and the threshold is 31.
- R2: A read strobe at address 0 with data stored returns the oldest byte on `reg_rdata[7:0]` in the same cycle, with the upper bits 0, and removes that byte. Reads in consecutive cycles each remove one byte.
- R3: The FIFO holds 32 bytes. Status bits 13..8 give the number of stored bytes, 0 to 32.
- R4: A write strobe at address 1 loads `reg_wdata[4:0]` as the threshold and ignores bits 7..5. Reading address 1 or 3 returns 0.
- R5: Status bit 7 is 1 exactly when the stored count is strictly greater than the threshold. Status bits 6..0 are 0.
- R6: Status bit 15 sets when a byte is offered while the FIFO is full and no byte is removed in that cycle. That byte is discarded and the stored bytes are unchanged.
- R7: Status bit 14 sets when address 0 is read while the FIFO is empty. That read returns 0x0000.
- R8: A read of the status register (address 2) clears bits 15 and 14 after the cycle. If a new overflow or underflow happens in that same cycle, its flag stays set.
- R9: `irq` equals status bit 7 ANDed with `irq_en`. It stays high until the count falls to the threshold or below.
- R10: A byte offered in the same cycle as a data read is always accepted when the FIFO is not empty, even at full, and the count does not change. On an empty FIFO the read underflows and the offered byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer offers a byte this cycle |
| push_data | input | 8 | Byte offered by the producer |
| reg_addr | input | 2 | Register select: 0 data, 1 threshold, 2 status |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from the current address |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Nearly-full interrupt request, level |

## Verification
The hardest case to reach is the one where several things happen in the same cycle. It covers a byte offered at full while the host also pops, and a status read that lands in the same cycle as a fresh overflow, where set must win over clear. The bench reaches it in two steps. First it fills the FIFO to exactly 32 through the port, which it can confirm from the fill field. Then it issues the coincident strobes in one cycle. A long random phase follows that mixes pushes, pops, threshold writes and status reads. A behavioural queue model is checked against the read data and the interrupt every cycle during that phase.

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int TW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic [1:0]    reg_addr,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          irq_en,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] A_DATA = 2'd0, A_THR = 2'd1, A_STAT = 2'd2;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [TW-1:0] thr;
  logic          ovf, udf;

  wire empty   = (count == '0);
  wire full    = (count == CW'(DEPTH));
  wire pop_req = reg_rd && reg_addr == A_DATA;
  wire pop     = pop_req && !empty;
  wire push    = push_valid && (!full || pop);
  wire stat_rd = reg_rd && reg_addr == A_STAT;
  wire trig    = count > CW'(thr);

  assign irq = trig && irq_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA: if (!empty) reg_rdata = 16'(mem[rd_ptr]);
      A_STAT: reg_rdata = {ovf, udf, 6'(count), trig, 7'b0};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      thr    <= TW'(DEPTH - 1);
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (reg_wr && reg_addr == A_THR) thr <= reg_wdata[TW-1:0];
      if (push_valid && !push)  ovf <= 1'b1;
      else if (stat_rd)         ovf <= 1'b0;
      if (pop_req && empty)     udf <= 1'b1;
      else if (stat_rd)         udf <= 1'b0;
    end
  end
endmodule

module rx_byte_fifo_chk #(parameter int CW = 6, parameter int DEPTH = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [CW-1:0] count,
  input logic          ovf,
  input logic          udf,
  input logic          irq,
  input logic          irq_en
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R3
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && count == CW'(DEPTH) && !(reg_rd && reg_addr == 2'd0) |=> ovf && count == CW'(DEPTH)); // R6
  AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 2'd0 && count == '0 |=> udf); // R7
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 2'd2 && !push_valid |=> !ovf && !udf); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> irq_en); // R9
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid && !(reg_rd && reg_addr == 2'd0) |=> $stable(count)); // R10
endmodule

bind rx_byte_fifo rx_byte_fifo_chk #(.CW(CW), .DEPTH(DEPTH)) chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .count(count), .ovf(ovf), .udf(udf), .irq(irq), .irq_en(irq_en));

// File: tb/rx_byte_fifo_test.sv
module rx_byte_fifo_test;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, reg_rd = 0, reg_wr = 0, irq_en = 0;
  logic [7:0] push_data = 0, reg_wdata = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  byte unsigned q[$];
  int thr = 31;
  bit m_ovf = 0, m_udf = 0;

  rx_byte_fifo uut (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] exp_rdata(logic [1:0] a);
    if (a == 2'd0) return (q.size() > 0) ? 16'(q[0]) : 16'h0;
    if (a == 2'd2) return {m_ovf, m_udf, 6'(q.size()), q.size() > thr, 7'b0};
    return 16'h0;
  endfunction

  task automatic cyc(bit pv, byte unsigned pd, logic [1:0] a, bit rd, bit wr,
                     byte unsigned wd, bit en, string tag);
    bit pop, full_b, emp_b;
    @(negedge clk);
    push_valid = pv; push_data = pd; reg_addr = a; reg_rd = rd;
    reg_wr = wr; reg_wdata = wd; irq_en = en;
    #1;
    checks++;
    if (reg_rdata !== exp_rdata(a)) begin
      errors++;
      $display("FAIL %s rdata addr %0d act %h exp %h", tag, a, reg_rdata, exp_rdata(a));
    end
    checks++;
    if (irq !== (en && q.size() > thr)) begin
      errors++;
      $display("FAIL R9 irq act %b exp %b", irq, en && q.size() > thr);
    end
    @(posedge clk);
    emp_b = (q.size() == 0);
    full_b = (q.size() == 32);
    pop = rd && a == 2'd0 && !emp_b;
    if (rd && a == 2'd2) begin m_ovf = 0; m_udf = 0; end
    if (rd && a == 2'd0 && emp_b) m_udf = 1;
    if (pop) void'(q.pop_front());
    if (pv) begin
      if (!full_b || pop) q.push_back(pd);
      else m_ovf = 1;
    end
    if (wr && a == 2'd1) thr = wd & 8'h1F;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    cyc(0, 0, 2, 1, 0, 0, 1, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, "R1");
    for (int i = 0; i < 32; i++) cyc(1, 8'(i * 7 + 3), 2, 1, 0, 0, 1, "R3");
    cyc(0, 0, 2, 1, 0, 0, 1, "R5");
    cyc(1, 8'hEE, 1, 1, 0, 0, 1, "R4");
    cyc(0, 0, 2, 1, 0, 0, 1, "R6");
    cyc(0, 0, 2, 1, 0, 0, 1, "R8");
    cyc(1, 8'h5A, 0, 1, 0, 0, 1, "R10");
    cyc(0, 0, 2, 1, 0, 0, 0, "R10");
    cyc(0, 0, 1, 0, 1, 8'hE4, 1, "R4");
    cyc(0, 0, 2, 1, 0, 0, 1, "R5");
    for (int i = 0; i < 32; i++) cyc(0, 0, 0, 1, 0, 0, 1, "R2");
    cyc(0, 0, 0, 1, 0, 0, 1, "R7");
    cyc(0, 0, 2, 1, 0, 0, 1, "R7");
    cyc(0, 0, 2, 1, 0, 0, 1, "R8");
    cyc(1, 8'h77, 0, 1, 0, 0, 1, "R10");
    cyc(0, 0, 2, 1, 0, 0, 1, "R10");
    for (int i = 0; i < 31; i++) cyc(1, 8'(i), 3, 1, 0, 0, 1, "R4");
    cyc(1, 8'h99, 2, 1, 0, 0, 1, "R8");
    cyc(0, 0, 2, 1, 0, 0, 1, "R8");
    cyc(0, 0, 2, 1, 0, 0, 1, "R8");
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      bit pv = ($urandom_range(0, 2) != 0);
      if (r < 4)       cyc(pv, 8'($urandom), 0, 1, 0, 0, 1'($urandom), "R2");
      else if (r < 6)  cyc(pv, 8'($urandom), 2, 1, 0, 0, 1'($urandom), "R8");
      else if (r == 6) cyc(pv, 8'($urandom), 1, 0, 1, 8'($urandom), 1, "R5");
      else             cyc(pv, 8'($urandom), 3, 0, 0, 0, 1, "R3");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule